// File: doc/BRIEF.md
# ECC failure page address tracker

This block sits beside the read path of a serial NAND flash. For every page that the array read delivers, the decoder reports an outcome (clean, corrected or uncorrectable) together with the page address. The block folds these outcomes into a two-bit ECC status that covers everything read since the most recent read command. It also keeps the address of the latest page that could not be corrected, which matters most in continuous read mode, where one command streams many pages.

A host fetches that stored address over a single-lane SPI slave link. It sends one opcode byte, then one dummy byte, and then clocks in sixteen address bits, most significant first. The SPI pins are sampled by the block's own clock through synchronizers, so the whole design runs in one clock domain. The system clock must be at least six times faster than the SPI clock.

Top module: `ecc_fail_tracker`

## Requirements
- R1: After reset, `ecc_status` is 2'b00, the stored failing address is 16'h0000, and `spi_do_oe` is low.
- R2: While `ecc_en` is high, each page strobe updates the status. A page whose `pg_result[1]` is 1 (uncorrectable) sets the status to 2'b10 if the status had no uncorrectable mark (bit 1 clear), and to 2'b11 otherwise. A result of 2'b01 (corrected) raises 2'b00 to 2'b01. A result of 2'b00 (clean) changes nothing. The status never drops until the next read command.
- R3: The stored address is the `pg_addr` of the latest uncorrectable page seen while `ecc_en` was high.
- R4: A `rd_cmd` pulse clears the status to 2'b00 and leaves the stored address unchanged. A page strobe in the same cycle counts as the first page of the new read.
- R5: While `ecc_en` is low, page strobes change neither the status nor the stored address.
- R6: A frame uses SPI mode 0. DI is sampled on rising SCLK, MSB first. Opcode 8'hA9 is followed by 8 dummy bits, and then the 16-bit stored address appears on DO, MSB first. DO changes on falling SCLK edges, and the first address bit is valid after the falling edge that follows the last dummy bit.
- R7: `spi_do_oe` is high only during the 16-bit address phase of a frame while chip select is low. `spi_do` reads 0 whenever `spi_do_oe` is low.
- R8: An opcode other than 8'hA9 causes DO to stay undriven for the rest of that frame.
- R9: Raising chip select ends the frame and discards all partial shift state. The next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_en | input | 1 | ECC checking enabled |
| rd_cmd | input | 1 | One-cycle pulse at each new read command |
| pg_vld | input | 1 | One-cycle strobe: a page result is present |
| pg_addr | input | 16 | Address of the reported page |
| pg_result | input | 2 | 00 clean, 01 corrected, bit 1 set means uncorrectable |
| ecc_status | output | 2 | Accumulated ECC status since the last read command |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI clock |
| spi_di | input | 1 | SPI data into the block |
| spi_do | output | 1 | SPI data out of the block |
| spi_do_oe | output | 1 | Output enable for `spi_do` (low means high-impedance) |

## Verification
The bench exercises two uncorrectable pages in a single read and checks that the status reads 2'b11 and that the second address is returned. A design that kept the first failure, or that counted the second one as a fresh 2'b10, would be caught here. It checks that a corrected page cannot lower a 2'b10 status, and that a read command clears the status but keeps the address. It also checks a page strobe that arrives in the same cycle as a read command, and page strobes with checking turned off. On the serial side, it sends a wrong opcode, where any DO drive is an error, and a frame that is cut off in the middle of the address phase. After the cut-off frame, a design that kept stale shift state would return a shifted or garbled address on the next full read.

// File: rtl/ecc_trk_pkg.sv
// Shared types and constants for the ECC failure page address tracker.
package ecc_trk_pkg;

    // Accumulated status codes
    typedef enum logic [1:0] {
        ST_NONE       = 2'b00,
        ST_FIXED      = 2'b01,
        ST_FAIL_ONE   = 2'b10,
        ST_FAIL_MULTI = 2'b11
    } ecc_stat_e;

    // Serial frame phases
    typedef enum logic [1:0] {
        PH_OPCODE = 2'b00,
        PH_DUMMY  = 2'b01,
        PH_ADDR   = 2'b10,
        PH_IDLE   = 2'b11
    } phase_e;

    localparam logic [7:0] OP_FAIL_ADDR = 8'hA9;

    // Fold one page outcome into the running status
    function automatic logic [1:0] fold_status(input logic [1:0] cur, input logic [1:0] res);
        logic [1:0] nxt;
        nxt = cur;
        if (res[1]) begin
            nxt = cur[1] ? ST_FAIL_MULTI : ST_FAIL_ONE;
        end else if (res[0] && (cur == ST_NONE)) begin
            nxt = ST_FIXED;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Brings the asynchronous SPI pins into the clk domain and flags SCLK edges.
// Assumes clk runs at least six times faster than SCLK, so every level lasts
// several clk cycles. DI is delayed by the same number of stages as SCLK, so
// di_s is the value that was present at the detected edge.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic di,
    output logic cs_n_s,
    output logic di_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] di_pipe;
    logic [STAGES:0]   sclk_pipe;

    // Synchronizer chains, one extra SCLK stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe   <= '1;
            di_pipe   <= '0;
            sclk_pipe <= '0;
        end else begin
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
            di_pipe   <= {di_pipe[STAGES-2:0], di};
            sclk_pipe <= {sclk_pipe[STAGES-1:0], sclk};
        end
    end

    // Edge flags and synchronized levels
    always_comb begin
        cs_n_s    = cs_pipe[STAGES-1];
        di_s      = di_pipe[STAGES-1];
        sclk_rise = sclk_pipe[STAGES-1] & ~sclk_pipe[STAGES];
        sclk_fall = ~sclk_pipe[STAGES-1] & sclk_pipe[STAGES];
    end
endmodule

// File: rtl/ecc_status_keeper.sv
// Accumulates per-page ECC outcomes into a two-bit status and holds the
// address of the latest uncorrectable page. A read command clears the status
// only. A page in the same cycle as a read command counts toward the new read.
module ecc_status_keeper
    import ecc_trk_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              rd_cmd,
    input  logic              pg_vld,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [1:0]        pg_result,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] fail_addr
);
    logic [1:0] base_stat;
    logic [1:0] next_stat;
    logic       take_page;

    // Next-status selection
    always_comb begin
        base_stat = rd_cmd ? ST_NONE : status;
        take_page = pg_vld & ecc_en;
        next_stat = take_page ? fold_status(base_stat, pg_result) : base_stat;
    end

    // Status and failing address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status    <= ST_NONE;
            fail_addr <= '0;
        end else begin
            status <= next_stat;
            if (take_page && pg_result[1]) begin
                fail_addr <= pg_addr;
            end
        end
    end
endmodule

// File: rtl/spi_readback_shifter.sv
// Decodes a serial frame: opcode, dummy bits, then shifts out the stored
// address on falling SCLK edges. The address is captured at the end of the
// dummy phase, so page updates during the shift do not tear the value.
// Assumes synchronized inputs from spi_pin_sync and DUMMY_BITS >= 1.
module spi_readback_shifter
    import ecc_trk_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OP_W       = 8,
    parameter int DUMMY_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              di_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [ADDR_W-1:0] fail_addr,
    input  logic [OP_W-1:0]   opcode,
    output logic              do_bit,
    output logic              do_oe
);
    localparam int MAX_BITS = (ADDR_W > OP_W) ? ((ADDR_W > DUMMY_BITS) ? ADDR_W : DUMMY_BITS)
                                              : ((OP_W > DUMMY_BITS) ? OP_W : DUMMY_BITS);
    localparam int CNT_W = $clog2(MAX_BITS + 1);

    phase_e            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [OP_W-1:0]   op_sr;
    logic [OP_W-1:0]   op_next;
    logic [ADDR_W-1:0] addr_sr;
    logic              do_q;

    // Opcode with the current bit shifted in
    always_comb op_next = {op_sr[OP_W-2:0], di_s};

    // Frame phase, bit counter and opcode capture on rising SCLK
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            phase   <= PH_OPCODE;
            bit_cnt <= '0;
            op_sr   <= '0;
        end else if (sclk_rise) begin
            case (phase)
                PH_OPCODE: begin
                    op_sr <= op_next;
                    if (bit_cnt == CNT_W'(OP_W - 1)) begin
                        bit_cnt <= '0;
                        phase   <= (op_next == opcode) ? PH_DUMMY : PH_IDLE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_DUMMY: begin
                    if (bit_cnt == CNT_W'(DUMMY_BITS - 1)) begin
                        bit_cnt <= '0;
                        phase   <= PH_ADDR;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
                        bit_cnt <= '0;
                        phase   <= PH_IDLE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: begin
                    bit_cnt <= bit_cnt;
                end
            endcase
        end
    end

    // Address snapshot at the last dummy bit, shifted out on falling SCLK
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            addr_sr <= '0;
            do_q    <= 1'b0;
        end else if (sclk_rise && phase == PH_DUMMY && bit_cnt == CNT_W'(DUMMY_BITS - 1)) begin
            addr_sr <= fail_addr;
        end else if (sclk_fall && phase == PH_ADDR) begin
            do_q    <= addr_sr[ADDR_W-1];
            addr_sr <= {addr_sr[ADDR_W-2:0], 1'b0};
        end
    end

    // Drive only during the address phase of a selected frame
    always_comb begin
        do_oe  = !cs_n_s && (phase == PH_ADDR);
        do_bit = do_oe & do_q;
    end
endmodule

// File: rtl/ecc_fail_tracker.sv
// Top level: per-page ECC status accumulation plus serial readback of the
// latest uncorrectable page address. Single clock domain; the SPI pins are
// oversampled by clk.
module ecc_fail_tracker
    import ecc_trk_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int OP_W        = 8,
    parameter int DUMMY_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              rd_cmd,
    input  logic              pg_vld,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [1:0]        pg_result,
    output logic [1:0]        ecc_status,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_di,
    output logic              spi_do,
    output logic              spi_do_oe
);
    logic              cs_n_sync;
    logic              di_sync;
    logic              sclk_rise;
    logic              sclk_fall;
    logic [ADDR_W-1:0] fail_addr;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .di        (spi_di),
        .cs_n_s    (cs_n_sync),
        .di_s      (di_sync),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    ecc_status_keeper #(.ADDR_W(ADDR_W)) i_keeper (
        .clk       (clk),
        .rst_n     (rst_n),
        .ecc_en    (ecc_en),
        .rd_cmd    (rd_cmd),
        .pg_vld    (pg_vld),
        .pg_addr   (pg_addr),
        .pg_result (pg_result),
        .status    (ecc_status),
        .fail_addr (fail_addr)
    );

    spi_readback_shifter #(
        .ADDR_W     (ADDR_W),
        .OP_W       (OP_W),
        .DUMMY_BITS (DUMMY_BITS)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_sync),
        .di_s      (di_sync),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .fail_addr (fail_addr),
        .opcode    (OP_W'(OP_FAIL_ADDR)),
        .do_bit    (spi_do),
        .do_oe     (spi_do_oe)
    );
endmodule

// File: rtl/ecc_fail_tracker_chk.sv
// Property checker for ecc_fail_tracker, attached through bind.
module ecc_fail_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ecc_en,
    input logic       rd_cmd,
    input logic       pg_vld,
    input logic [1:0] pg_result,
    input logic [1:0] ecc_status,
    input logic       cs_n_sync,
    input logic       sclk_rise,
    input logic       spi_do,
    input logic       spi_do_oe
);
    assert_cmd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !(pg_vld && ecc_en)) |=> (ecc_status == 2'b00));

    assert_no_downgrade_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd && ecc_status[1]) |=> ecc_status[1]);

    assert_second_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd && ecc_en && pg_vld && pg_result[1] && ecc_status[1]) |=> (ecc_status == 2'b11));

    assert_uncorr_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && pg_vld && pg_result[1]) |=> ecc_status[1]);

    assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd && !ecc_en) |=> $stable(ecc_status));

    assert_cs_high_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_sync |=> !spi_do_oe);

    assert_do_zero_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_do_oe |-> !spi_do);

    assert_oe_on_sclk_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_do_oe) |-> $past(sclk_rise));
endmodule

bind ecc_fail_tracker ecc_fail_tracker_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ecc_en     (ecc_en),
    .rd_cmd     (rd_cmd),
    .pg_vld     (pg_vld),
    .pg_result  (pg_result),
    .ecc_status (ecc_status),
    .cs_n_sync  (cs_n_sync),
    .sclk_rise  (sclk_rise),
    .spi_do     (spi_do),
    .spi_do_oe  (spi_do_oe)
);

// File: tb/test_ecc_fail_tracker.sv
module test_ecc_fail_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SPI   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b1;
    logic        rd_cmd = 1'b0;
    logic        pg_vld = 1'b0;
    logic [15:0] pg_addr = '0;
    logic [1:0]  pg_result = '0;
    logic [1:0]  ecc_status;
    logic        spi_cs_n = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_di = 1'b0;
    logic        spi_do;
    logic        spi_do_oe;

    int          n_vec = 0;
    int          n_err = 0;
    logic [1:0]  exp_stat = 2'b00;
    logic [15:0] exp_addr = 16'h0000;
    logic [15:0] exp_q[$];
    logic        oe_seen = 1'b0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_fail_tracker i_ecc_fail_tracker (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .rd_cmd(rd_cmd),
        .pg_vld(pg_vld), .pg_addr(pg_addr), .pg_result(pg_result),
        .ecc_status(ecc_status), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_di(spi_di), .spi_do(spi_do), .spi_do_oe(spi_do_oe)
    );

    always @(posedge clk) if (spi_do_oe) oe_seen <= 1'b1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: one cycle of page/command stimulus plus the reference model
    task automatic drive(input logic rd, input logic en, input logic vld,
                         input logic [15:0] a, input logic [1:0] res);
        logic [1:0] b;
        @(negedge clk);
        rd_cmd = rd; ecc_en = en; pg_vld = vld; pg_addr = a; pg_result = res;
        b = rd ? 2'b00 : exp_stat;
        if (vld && en) begin
            if (res[1]) begin
                b = b[1] ? 2'b11 : 2'b10;
                exp_addr = a;
            end else if (res == 2'b01 && b == 2'b00) begin
                b = 2'b01;
            end
        end
        exp_stat = b;
        @(negedge clk);
        rd_cmd = 1'b0; pg_vld = 1'b0;
    endtask

    task automatic spi_bit(input logic b);
        spi_di = b;
        spi_sclk = 1'b0;
        repeat (HALF_SPI) @(negedge clk);
        spi_sclk = 1'b1;
        repeat (HALF_SPI) @(negedge clk);
    endtask

    // Frame: opcode, then nbits more clocks (dummy + address), then deselect
    task automatic spi_frame(input logic [7:0] op, input int nbits, input bit expect_addr);
        if (expect_addr) exp_q.push_back(exp_addr);
        oe_seen = 1'b0;
        spi_cs_n = 1'b0;
        repeat (HALF_SPI) @(negedge clk);
        for (int i = 7; i >= 0; i--) spi_bit(op[i]);
        for (int i = 0; i < nbits; i++) spi_bit(1'b0);
        spi_sclk = 1'b0;
        repeat (HALF_SPI) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (HALF_SPI) @(negedge clk);
    endtask

    // Monitor: collects DO bits at rising SCLK while driven, compares to queue
    initial begin
        logic [15:0] got;
        int          cnt;
        got = '0; cnt = 0;
        forever begin
            @(posedge spi_sclk or posedge spi_cs_n);
            if (spi_cs_n) begin
                cnt = 0;
            end else if (spi_do_oe) begin
                got = {got[14:0], spi_do};
                cnt++;
                if (cnt == 16) begin
                    cnt = 0;
                    if (exp_q.size() == 0) check("R6 unexpected readback", {16'h0, got}, 32'hFFFF_FFFF);
                    else check("R6/R3 readback address", {16'h0, got}, {16'h0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_vec++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", ecc_status, 2'b00);
        check("R1 oe", spi_do_oe, 1'b0);
        spi_frame(8'hA9, 24, 1'b1);               // R1 stored address is 0000

        // R2 clean pages leave 00, corrected raises to 01
        drive(1, 1, 1, 16'h0010, 2'b00);
        drive(0, 1, 1, 16'h0011, 2'b00);
        check("R2 clean", ecc_status, exp_stat);
        drive(0, 1, 1, 16'h0012, 2'b01);
        check("R2 corrected", ecc_status, 2'b01);

        // R2/R3 single uncorrectable page
        drive(0, 1, 1, 16'hBEEF, 2'b10);
        check("R2 one fail", ecc_status, 2'b10);
        drive(0, 1, 1, 16'h0013, 2'b01);
        check("R2 no downgrade", ecc_status, 2'b10);
        spi_frame(8'hA9, 24, 1'b1);

        // R2/R3 second failing page wins, result 2'b11 also uncorrectable
        drive(0, 1, 1, 16'h5A3C, 2'b11);
        check("R2 multi fail", ecc_status, 2'b11);
        check("R3 model", exp_addr, 16'h5A3C);
        spi_frame(8'hA9, 24, 1'b1);

        // R4 read command clears status, keeps address
        drive(1, 1, 0, 16'h0000, 2'b00);
        check("R4 cleared", ecc_status, 2'b00);
        spi_frame(8'hA9, 24, 1'b1);

        // R4 page in same cycle as read command counts for new read
        drive(0, 1, 1, 16'h0001, 2'b10);
        drive(1, 1, 1, 16'h8001, 2'b10);
        check("R4 same-cycle page", ecc_status, 2'b10);

        // R5 disabled checking ignores pages
        drive(0, 0, 1, 16'h7777, 2'b10);
        check("R5 status held", ecc_status, 2'b10);
        drive(1, 0, 1, 16'h6666, 2'b01);
        check("R5 status after cmd", ecc_status, 2'b00);
        spi_frame(8'hA9, 24, 1'b1);               // R5 address still 8001

        // R8 other opcode never drives DO
        spi_frame(8'hA8, 24, 1'b0);
        check("R8 no drive", oe_seen, 1'b0);
        spi_frame(8'h29, 24, 1'b0);
        check("R8 no drive msb", oe_seen, 1'b0);

        // R9 frame cut in address phase, then a fresh frame
        drive(0, 1, 1, 16'hC3A5, 2'b10);
        spi_frame(8'hA9, 13, 1'b0);
        check("R7 oe low after cs", spi_do_oe, 1'b0);
        spi_frame(8'hA9, 24, 1'b1);               // R9 clean restart
        spi_frame(8'hA9, 3, 1'b0);
        check("R9 cut in dummy no drive", oe_seen, 1'b0);
        spi_frame(8'hA9, 24, 1'b1);

        repeat (20) @(negedge clk);
        check("R6 all readbacks seen", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule